// File: doc/BRIEF.md
# Multi-source brown-out reset controller

This block turns four digitized supply comparators into one device reset. The four monitors watch the core supply, the main supply, the battery supply and the supply used in deep sleep. Each monitor counts only in certain power modes and only when its enable rule is met. A monitor that meets those conditions while its comparator reports a low supply is called a qualified trip. Any qualified trip holds the device in reset. While the reset is held, the block tri-states the output pins. It also emits a one-cycle strobe that tells the register file to load its brown-out values, including the deep-sleep holding registers.

The comparator levels are resynchronized before they are used. A reset is released only after every monitor has stayed quiet for a fixed number of consecutive cycles. Each monitor leaves a sticky status flag, which software clears by writing a one. While the reset is held, the block also presents the power mode that the device enters on release. That mode is battery mode when the battery monitor alone caused the episode, and run mode otherwise.

Top module: `bor_reset_ctrl`

## Requirements
- R1: The core-supply monitor (comparator bit 0) has no enable and qualifies only when `pwr_mode` is run (0), idle (1) or sleep (2). It has no effect in deep sleep (3), in battery mode (4), or for codes 5 to 7.
- R2: The main-supply monitor (comparator bit 1) qualifies only in run, idle or sleep and only while `en_main` is 1.
- R3: The battery-supply monitor (comparator bit 2) qualifies only in battery mode (4) and only while `en_batt` is 1.
- R4: The deep-sleep monitor (comparator bit 3) qualifies only in deep sleep (3) and only while `en_dsleep` is 1.
- R5: A comparator rising while its qualifying conditions already hold raises `rst_hold` on the third rising clock edge after the change. The three edges are two synchronizer stages and the hold register. A qualifying condition that becomes true while the synchronized comparator is already high raises `rst_hold` on the next edge.
- R6: `rst_hold` falls after 16 consecutive edges with no qualified trip, which is the 18th edge after the last comparator falls. A trip at any point in that window restarts the count, and the hold stays high.
- R7: `io_tristate` equals `rst_hold` on every cycle. `rf_rst` is high for exactly one cycle, on the first cycle of each hold episode.
- R8: `bor_flags[i]` becomes 1 on the edge after source i has a qualified trip. It stays 1 until a 1 is written on `flag_clr[i]`, which clears it on the next edge. A trip in the same cycle as the clear wins, and the flag stays 1.
- R9: While `por_n` is low, `rst_hold`, `rf_rst` and `bor_flags` are 0 and `exit_mode` is run (0). This also applies when `por_n` goes low in the middle of a hold.
- R10: `exit_mode` is battery mode (4) when the battery monitor is the only source that tripped during the current hold episode, and run mode (0) otherwise. The value stays in place after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| pwr_mode | input | 3 | Current power mode: 0 run, 1 idle, 2 sleep, 3 deep sleep, 4 battery |
| en_main | input | 1 | Enable for the main-supply monitor |
| en_batt | input | 1 | Enable for the battery-supply monitor |
| en_dsleep | input | 1 | Enable for the deep-sleep monitor |
| cmp_low | input | 4 | Comparator levels, 1 = supply below trip: bit0 core, bit1 main, bit2 battery, bit3 deep sleep |
| flag_clr | input | 4 | Write-one-to-clear pulses for the status flags |
| rst_hold | output | 1 | Device held in reset |
| io_tristate | output | 1 | Tri-state command for output pins |
| rf_rst | output | 1 | One-cycle register-file brown-out reset strobe |
| bor_flags | output | 4 | Sticky per-source brown-out flags |
| exit_mode | output | 3 | Power mode to enter when the reset is released |

## Verification
Each monitor is driven low with its comparator high, once in a mode outside its window and once with its enable cleared. The hold must not appear until the missing condition is supplied. This separates the mode window from the enable gate for every source. A comparator that drops for ten cycles and then returns tells a restarting quiet count from one that accumulates. Releases sampled at the 17th and 18th edges fix the exact length of the quiet window. A battery-only episode, a mixed episode in which battery mode changes to run during the hold, and two sources tripping together tell the three outcomes of the exit-mode rule apart. An early power-on reset during a battery hold shows that every output returns to its cleared value.

// File: rtl/bor_pkg.sv
package bor_pkg;

  localparam int NUM_SRC  = 4;
  localparam int SRC_CORE = 0;
  localparam int SRC_MAIN = 1;
  localparam int SRC_BATT = 2;
  localparam int SRC_DS   = 3;

  typedef enum logic [2:0] {
    PM_RUN    = 3'd0,
    PM_IDLE   = 3'd1,
    PM_SLEEP  = 3'd2,
    PM_DSLEEP = 3'd3,
    PM_BATT   = 3'd4
  } pmode_e;

  // Mode window of each monitor: the modes in which it may cause a reset.
  function automatic logic src_window(int src, logic [2:0] mode);
    logic awake;
    awake = (mode == PM_RUN) || (mode == PM_IDLE) || (mode == PM_SLEEP);
    case (src)
      SRC_CORE: return awake;
      SRC_MAIN: return awake;
      SRC_BATT: return mode == PM_BATT;
      SRC_DS:   return mode == PM_DSLEEP;
      default:  return 1'b0;
    endcase
  endfunction

  // Enable rule: the core monitor carries a constant 1 in the vector.
  function automatic logic src_gate(int src, logic [NUM_SRC-1:0] en_vec);
    return en_vec[src];
  endfunction

  // Destination on release: battery only when it alone caused the episode.
  function automatic logic [2:0] exit_for(logic [NUM_SRC-1:0] seen);
    logic [NUM_SRC-1:0] batt_only;
    batt_only = '0;
    batt_only[SRC_BATT] = 1'b1;
    return (seen == batt_only) ? PM_BATT : PM_RUN;
  endfunction

endpackage

// File: rtl/bor_sync.sv
module bor_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/bor_qualify.sv
module bor_qualify
  import bor_pkg::*;
#(
  parameter int NSRC = NUM_SRC
) (
  input  logic [2:0]      mode,
  input  logic [NSRC-1:0] en_vec,
  input  logic [NSRC-1:0] cmp_s,
  output logic [NSRC-1:0] trip
);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign trip[g] = cmp_s[g] & src_gate(g, en_vec) & src_window(g, mode);
  end

endmodule

// File: rtl/bor_release.sv
module bor_release
  import bor_pkg::*;
#(
  parameter int NSRC  = NUM_SRC,
  parameter int QUIET = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  trip,
  output logic             hold,
  output logic             rf_pulse,
  output logic [2:0]       exit_mode,
  output logic [$clog2(QUIET+1)-1:0] quiet_cnt
);

  localparam int CNT_W = $clog2(QUIET + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUIET - 1);

  logic             trip_any;
  logic [NSRC-1:0]  seen_q;
  logic [NSRC-1:0]  seen_nx;
  logic [CNT_W-1:0] cnt_q;

  assign trip_any = |trip;
  assign seen_nx  = (hold ? seen_q : '0) | trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= 1'b0;
      rf_pulse  <= 1'b0;
      cnt_q     <= '0;
      seen_q    <= '0;
      exit_mode <= PM_RUN;
    end else begin
      rf_pulse <= trip_any & ~hold;
      if (trip_any) begin
        hold      <= 1'b1;
        cnt_q     <= '0;
        seen_q    <= seen_nx;
        exit_mode <= exit_for(seen_nx);
      end else if (hold) begin
        if (cnt_q == LAST) begin
          hold  <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign quiet_cnt = cnt_q;

endmodule

// File: rtl/bor_status.sv
module bor_status #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] trip,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] flags
);

  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flags[g] <= 1'b0;
      else if (trip[g])  flags[g] <= 1'b1;
      else if (clr[g])   flags[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/bor_reset_ctrl.sv
module bor_reset_ctrl
  import bor_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int QUIET_CYCLES = 16
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [2:0]   pwr_mode,
  input  logic         en_main,
  input  logic         en_batt,
  input  logic         en_dsleep,
  input  logic [3:0]   cmp_low,
  input  logic [3:0]   flag_clr,
  output logic         rst_hold,
  output logic         io_tristate,
  output logic         rf_rst,
  output logic [3:0]   bor_flags,
  output logic [2:0]   exit_mode
);

  localparam int CNT_W = $clog2(QUIET_CYCLES + 1);

  logic [NUM_SRC-1:0] en_vec;
  logic [NUM_SRC-1:0] cmp_sync;
  logic [NUM_SRC-1:0] trip_vec;
  logic               trip_any;
  logic [CNT_W-1:0]   quiet_cnt;

  always_comb begin
    en_vec           = '0;
    en_vec[SRC_CORE] = 1'b1;
    en_vec[SRC_MAIN] = en_main;
    en_vec[SRC_BATT] = en_batt;
    en_vec[SRC_DS]   = en_dsleep;
  end

  bor_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d     (cmp_low),
    .q     (cmp_sync)
  );

  bor_qualify #(.NSRC(NUM_SRC)) u_qual (
    .mode   (pwr_mode),
    .en_vec (en_vec),
    .cmp_s  (cmp_sync),
    .trip   (trip_vec)
  );

  assign trip_any = |trip_vec;

  bor_release #(.NSRC(NUM_SRC), .QUIET(QUIET_CYCLES)) u_rel (
    .clk       (clk),
    .rst_n     (por_n),
    .trip      (trip_vec),
    .hold      (rst_hold),
    .rf_pulse  (rf_rst),
    .exit_mode (exit_mode),
    .quiet_cnt (quiet_cnt)
  );

  bor_status #(.NSRC(NUM_SRC)) u_stat (
    .clk   (clk),
    .rst_n (por_n),
    .trip  (trip_vec),
    .clr   (flag_clr),
    .flags (bor_flags)
  );

  assign io_tristate = rst_hold;

endmodule

// File: rtl/bor_reset_ctrl_chk.sv
module bor_reset_ctrl_chk (
  input logic       clk,
  input logic       por_n,
  input logic [2:0] pwr_mode,
  input logic       en_main,
  input logic       en_batt,
  input logic       en_dsleep,
  input logic [3:0] flag_clr,
  input logic       rst_hold,
  input logic       io_tristate,
  input logic       rf_rst,
  input logic [3:0] bor_flags,
  input logic [2:0] exit_mode,
  input logic [3:0] trip_vec,
  input logic       trip_any
);

  assert_core_window_R1: assert property (@(posedge clk) disable iff (!por_n)
    trip_vec[0] |-> (pwr_mode <= 3'd2));

  assert_main_gate_R2: assert property (@(posedge clk) disable iff (!por_n)
    trip_vec[1] |-> (en_main && pwr_mode <= 3'd2));

  assert_batt_gate_R3: assert property (@(posedge clk) disable iff (!por_n)
    trip_vec[2] |-> (en_batt && pwr_mode == 3'd4));

  assert_ds_gate_R4: assert property (@(posedge clk) disable iff (!por_n)
    trip_vec[3] |-> (en_dsleep && pwr_mode == 3'd3));

  assert_entry_R5: assert property (@(posedge clk) disable iff (!por_n)
    trip_any |=> rst_hold);

  assert_release_quiet_R6: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_hold) |-> !$past(trip_any));

  assert_tristate_R7: assert property (@(posedge clk) disable iff (!por_n)
    io_tristate == rst_hold);

  assert_strobe_once_R7: assert property (@(posedge clk) disable iff (!por_n)
    rf_rst |=> !rf_rst);

  assert_strobe_entry_R7: assert property (@(posedge clk) disable iff (!por_n)
    rf_rst |-> (rst_hold && !$past(rst_hold)));

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!por_n)
    (trip_vec != 4'd0) |=> ((bor_flags & $past(trip_vec)) == $past(trip_vec)));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!por_n)
    por_n |=> (($past(bor_flags) & ~$past(flag_clr) & ~bor_flags) == 4'd0));

  assert_por_R9: assert property (@(posedge clk)
    !por_n |-> (!rst_hold && !rf_rst && bor_flags == 4'd0 && exit_mode == 3'd0));

  assert_exit_code_R10: assert property (@(posedge clk) disable iff (!por_n)
    rst_hold |-> (exit_mode == 3'd0 || exit_mode == 3'd4));

endmodule

bind bor_reset_ctrl bor_reset_ctrl_chk u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .pwr_mode    (pwr_mode),
  .en_main     (en_main),
  .en_batt     (en_batt),
  .en_dsleep   (en_dsleep),
  .flag_clr    (flag_clr),
  .rst_hold    (rst_hold),
  .io_tristate (io_tristate),
  .rf_rst      (rf_rst),
  .bor_flags   (bor_flags),
  .exit_mode   (exit_mode),
  .trip_vec    (trip_vec),
  .trip_any    (trip_any)
);

// File: tb/sim_bor_reset_ctrl.sv
module sim_bor_reset_ctrl;

  logic       clk = 1'b0;
  logic       por_n;
  logic [2:0] pwr_mode;
  logic       en_main, en_batt, en_dsleep;
  logic [3:0] cmp_low, flag_clr;
  logic       rst_hold, io_tristate, rf_rst;
  logic [3:0] bor_flags;
  logic [2:0] exit_mode;

  always #10 clk = ~clk;

  bor_reset_ctrl u0 (
    .clk(clk), .por_n(por_n), .pwr_mode(pwr_mode), .en_main(en_main),
    .en_batt(en_batt), .en_dsleep(en_dsleep), .cmp_low(cmp_low),
    .flag_clr(flag_clr), .rst_hold(rst_hold), .io_tristate(io_tristate),
    .rf_rst(rf_rst), .bor_flags(bor_flags), .exit_mode(exit_mode)
  );

  // field codes: 0 hold, 1 tristate, 2 strobe, 3 flags, 4 exit mode
  typedef struct {
    int    at;
    int    fld;
    int    val;
    string req;
  } item_t;

  item_t sbq[$];
  int    cyc   = 0;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int peek(int fld);
    case (fld)
      0: return int'(rst_hold);
      1: return int'(io_tristate);
      2: return int'(rf_rst);
      3: return int'(bor_flags);
      default: return int'(exit_mode);
    endcase
  endfunction

  task automatic push(int dt, int fld, int val, string req);
    item_t it;
    int    i;
    it.at = cyc + dt; it.fld = fld; it.val = val; it.req = req;
    i = 0;
    while (i < sbq.size() && sbq[i].at <= it.at) i++;
    sbq.insert(i, it);
  endtask

  // monitor: pops items whose cycle has come and compares
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      item_t it;
      int    act;
      it  = sbq.pop_front();
      act = peek(it.fld);
      n_cmp++;
      if (it.at != cyc || act != it.val) begin
        n_bad++;
        $display("FAIL %s field=%0d cycle=%0d actual=%0d expected=%0d",
                 it.req, it.fld, it.at, act, it.val);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (sbq.size() > 0) @(negedge clk);
    tick(1);
  endtask

  task automatic clear_all();
    flag_clr = 4'hF;
    push(1, 3, 0, "R8");
    tick(1);
    flag_clr = 4'h0;
    tick(2);
  endtask

  initial begin
    por_n = 1'b0; pwr_mode = 3'd0;
    en_main = 1'b1; en_batt = 1'b1; en_dsleep = 1'b1;
    cmp_low = 4'h0; flag_clr = 4'h0;
    tick(3);
    por_n = 1'b1;
    push(1, 0, 0, "R9"); push(1, 2, 0, "R9");
    push(1, 3, 0, "R9"); push(1, 4, 0, "R9");
    tick(4);

    // R1/R5/R7: core monitor trips in run mode
    cmp_low = 4'b0001;
    push(2, 0, 0, "R5"); push(3, 0, 1, "R5"); push(3, 1, 1, "R7");
    push(3, 2, 1, "R7"); push(4, 2, 0, "R7"); push(3, 3, 1, "R1");
    push(3, 4, 0, "R10");
    tick(30);
    cmp_low = 4'b0000;
    push(17, 0, 1, "R6"); push(18, 0, 0, "R6"); push(18, 1, 0, "R7");
    push(19, 3, 1, "R8");
    tick(20); drain();
    flag_clr = 4'b0001; push(1, 3, 0, "R8"); tick(1); flag_clr = 4'h0; tick(2);

    // R2: main monitor disabled in idle, then enabled
    en_main = 1'b0; pwr_mode = 3'd1; cmp_low = 4'b0010;
    push(3, 0, 0, "R2"); push(10, 0, 0, "R2"); push(25, 3, 0, "R2");
    tick(30);
    en_main = 1'b1;
    push(1, 0, 1, "R2"); push(1, 3, 2, "R2"); push(1, 2, 1, "R7");
    tick(5);
    cmp_low = 4'b0000; push(18, 0, 0, "R6");
    tick(20); drain(); clear_all();

    // R1/R4: deep sleep, core out of window, deep-sleep monitor gated
    pwr_mode = 3'd3; en_dsleep = 1'b0; cmp_low = 4'b1001;
    push(5, 0, 0, "R1"); push(25, 0, 0, "R4"); push(25, 3, 0, "R4");
    tick(30);
    en_dsleep = 1'b1;
    push(1, 0, 1, "R4"); push(1, 3, 8, "R4"); push(1, 4, 0, "R10");
    tick(5);
    cmp_low = 4'b0000;
    push(17, 0, 1, "R6"); push(18, 0, 0, "R6"); push(18, 4, 0, "R10");
    tick(20); drain(); clear_all();

    // R3/R10/R9: battery monitor, exit to battery, power-on reset mid-hold
    pwr_mode = 3'd4; en_batt = 1'b0; cmp_low = 4'b0100;
    push(20, 0, 0, "R3");
    tick(25);
    en_batt = 1'b1;
    push(1, 0, 1, "R3"); push(1, 3, 4, "R3"); push(1, 4, 4, "R10");
    tick(5);
    por_n = 1'b0;
    push(1, 0, 0, "R9"); push(1, 3, 0, "R9"); push(1, 4, 0, "R9");
    tick(3);
    por_n = 1'b1;
    push(2, 0, 0, "R5"); push(3, 0, 1, "R5"); push(3, 4, 4, "R10");
    tick(6);
    cmp_low = 4'b0000;
    push(17, 0, 1, "R6"); push(18, 0, 0, "R6"); push(20, 4, 4, "R10");
    tick(22); drain(); clear_all();

    // R10: battery episode joined by core after a switch to run
    pwr_mode = 3'd4; cmp_low = 4'b0101;
    push(3, 0, 1, "R10"); push(3, 4, 4, "R10"); push(3, 3, 4, "R3");
    tick(8);
    pwr_mode = 3'd0;
    push(1, 4, 0, "R10"); push(1, 3, 5, "R8");
    tick(5);
    cmp_low = 4'b0000;
    push(18, 0, 0, "R6"); push(18, 4, 0, "R10");
    tick(20); drain(); clear_all();

    // R8/R6: simultaneous trip, set beats clear, interrupted quiet window
    cmp_low = 4'b0011;
    push(3, 3, 3, "R8"); push(3, 4, 0, "R10"); push(3, 2, 1, "R7");
    tick(8);
    flag_clr = 4'b0001; push(1, 3, 3, "R8"); tick(1); flag_clr = 4'h0;
    tick(3);
    cmp_low = 4'b0000;
    push(17, 0, 1, "R6"); push(18, 0, 1, "R6"); push(26, 0, 1, "R6");
    push(13, 2, 0, "R7");
    tick(10);
    cmp_low = 4'b0011;
    tick(20);
    cmp_low = 4'b0000;
    push(17, 0, 1, "R6"); push(18, 0, 0, "R6");
    tick(20); drain(); clear_all();

    drain();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule